// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar Counter

This block keeps wall-clock time and calendar date in seven byte-wide registers, each holding binary-coded decimal digits: seconds, minutes, hours, day of month, month, day of week and a two-digit year. A one-cycle pulse on `tick_i` advances the time by one second. Carries ripple from seconds through minutes and hours into the calendar fields within that same clock cycle. The calendar knows the length of each month, including leap Februaries in years divisible by four.

Bit 7 of the seconds register stops the count while it is set. Bit 7 of the hours register chooses between a 24-hour format and a 12-hour format with an AM/PM flag, and bit 5 changes meaning with that choice. A host writes any register through a one-byte write port and reads any register through a registered read port. A host write always beats a tick that arrives in the same cycle.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: After synchronous reset the registers read seconds 0x00 (running), minutes 0x00, hours 0x00 (24-hour mode), date 0x01, month 0x01, day-of-week 0x01, year 0x00.
- R2: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day-of-week, 6 year. A write stores the byte at the next clock edge. `rd_data_o` shows the register selected by `rd_addr_i` one cycle later. Address 7 reads 0x00, and a write to address 7 has no effect.
- R3: Seconds (bits 6:0) and minutes count in BCD from 00 to 59. Each wraps to 00 and carries into the next field. A field below 59 does not carry.
- R4: When seconds bit 7 is 1, ticks change no register. When a write clears that bit, counting resumes on the next tick. Counting never alters bit 7.
- R5: With hours bit 7 at 0 (24-hour mode), bits 5:0 hold BCD hours 00 to 23, with bit 5 as the tens bit for 20 to 23. A step from 23 gives 00 and advances the date.
- R6: With hours bit 7 at 1 (12-hour mode), bit 5 is PM (1) or AM (0), and bits 4:0 hold BCD 01 to 12. The sequence runs 12, 01, …, 11, 12. The step from 11 to 12 flips the PM bit. Only the step from 11 PM to 12 AM advances the date.
- R7: A date step from the last day of a month gives day 01 and the next month. Months 04, 06, 09 and 11 have 30 days. Months 01, 03, 05, 07, 08, 10 and 12 have 31.
- R8: February has 29 days when the BCD year is a multiple of four (00 counts), and 28 days otherwise.
- R9: A month step from 12 gives 01 and advances the year. Year 99 wraps to 00.
- R10: Every date step also advances the day-of-week, from 7 back to 1 and otherwise by one.
- R11: When a write and a tick arrive in the same cycle, the write is applied and the tick is discarded. No register advances in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, one second elapsed |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Register address for writes |
| wr_data_i | input | 8 | Byte to store |
| rd_addr_i | input | 3 | Register address for reads |
| rd_data_o | output | 8 | Registered read data |

## Verification
A host write and a seconds tick can land on the same clock edge. The bench provokes this by raising both strobes in one cycle, once with seconds at 59 so that a wrongly taken tick would carry into the minutes, and once with the write aimed at another register. The outcome is judged by reading back all seven registers: the written byte must be stored and every other field must be unchanged. A further plain tick must then advance the clock from the written value with the expected carries.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 7;
  localparam int SEL_W    = $clog2(NUM_REGS + 1);

  typedef enum logic [SEL_W-1:0] {
    REG_SEC   = 3'd0,
    REG_MIN   = 3'd1,
    REG_HOUR  = 3'd2,
    REG_DATE  = 3'd3,
    REG_MONTH = 3'd4,
    REG_DOW   = 3'd5,
    REG_YEAR  = 3'd6
  } reg_sel_e;

  // Two-digit BCD increment; caller handles the wrap value.
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Multiple of four on a BCD year: even tens -> ones 0/4/8, odd tens -> 2/6.
  function automatic logic bcd_leap(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_time.sv
module bcd_rtc_time
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              wr_sec_i,
  input  logic              wr_min_i,
  input  logic              wr_hour_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic              day_step_o
);
  logic [BYTE_W-1:0] sec_q, min_q, hour_q;
  logic [BYTE_W-1:0] sec_inc, min_inc, h24_inc, h12_inc, hour_next;
  logic sec_wrap, min_wrap, hour_step, hour_carry;

  always_comb begin
    sec_inc  = bcd_next({1'b0, sec_q[6:0]});
    min_inc  = bcd_next(min_q);
    h24_inc  = bcd_next({2'b00, hour_q[5:0]});
    h12_inc  = bcd_next({3'b000, hour_q[4:0]});
    sec_wrap = (sec_q[6:0] == 7'h59);
    min_wrap = (min_q == 8'h59);
    hour_carry = 1'b0;
    if (hour_q[7]) begin
      if (hour_q[4:0] == 5'h11) begin
        hour_next  = {2'b10, ~hour_q[5], 5'h12};
        hour_carry = hour_q[5];               // 11 PM -> 12 AM
      end else if (hour_q[4:0] == 5'h12) begin
        hour_next  = {2'b10, hour_q[5], 5'h01};
      end else begin
        hour_next  = h12_inc | {2'b10, hour_q[5], 5'h00};
      end
    end else if (hour_q[6:0] == 7'h23) begin
      hour_next  = 8'h00;
      hour_carry = 1'b1;
    end else begin
      hour_next  = h24_inc;
    end
    hour_step  = adv_i && sec_wrap && min_wrap;
    day_step_o = hour_step && hour_carry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (wr_sec_i)   sec_q <= wr_data_i;
      else if (adv_i) sec_q <= sec_wrap ? {sec_q[7], 7'h00} : (sec_inc | {sec_q[7], 7'h00});
      if (wr_min_i)               min_q <= wr_data_i;
      else if (adv_i && sec_wrap) min_q <= min_wrap ? 8'h00 : min_inc;
      if (wr_hour_i)      hour_q <= wr_data_i;
      else if (hour_step) hour_q <= hour_next;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;

  // R3: minutes hold while seconds have not reached 59
  p_min_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !sec_wrap && !wr_min_i) |=> $stable(min_q));
  // R6: the 11 -> 12 step in 12-hour mode flips the PM flag
  p_pm_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (hour_step && !wr_hour_i && hour_q[7] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5])));
  // R4: counting never touches the halt bit
  p_halt_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !wr_sec_i) |=> (sec_q[7] == $past(sec_q[7])));
endmodule

// File: rtl/bcd_rtc_date.sv
module bcd_rtc_date
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              day_step_i,
  input  logic              wr_date_i,
  input  logic              wr_month_i,
  input  logic              wr_dow_i,
  input  logic              wr_year_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] date_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] dow_o,
  output logic [BYTE_W-1:0] year_o
);
  logic [BYTE_W-1:0] date_q, month_q, dow_q, year_q, last_day;
  logic leap, date_wrap, month_wrap, year_wrap;

  always_comb begin
    leap       = bcd_leap(year_q);
    last_day   = month_last_day(month_q, leap);
    date_wrap  = (date_q == last_day);
    month_wrap = (month_q == 8'h12);
    year_wrap  = (year_q == 8'h99);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      date_q  <= 8'h01;
      month_q <= 8'h01;
      dow_q   <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (wr_date_i)       date_q <= wr_data_i;
      else if (day_step_i) date_q <= date_wrap ? 8'h01 : bcd_next(date_q);
      if (wr_month_i)                   month_q <= wr_data_i;
      else if (day_step_i && date_wrap) month_q <= month_wrap ? 8'h01 : bcd_next(month_q);
      if (wr_year_i) year_q <= wr_data_i;
      else if (day_step_i && date_wrap && month_wrap)
        year_q <= year_wrap ? 8'h00 : bcd_next(year_q);
      if (wr_dow_i)        dow_q <= wr_data_i;
      else if (day_step_i) dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
    end
  end

  assign date_o  = date_q;
  assign month_o = month_q;
  assign dow_o   = dow_q;
  assign year_o  = year_q;

  // R10: every date step moves the day-of-week
  p_dow_moves_r10: assert property (@(posedge clk) disable iff (rst)
    (day_step_i && !wr_dow_i) |=> (dow_q != $past(dow_q)));
  // R7: month holds unless the date wraps
  p_month_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!(day_step_i && date_wrap) && !wr_month_i) |=> $stable(month_q));
endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [7:0]       rd_data_o
);
  localparam int ALL_W = NUM_REGS * BYTE_W;

  logic [NUM_REGS-1:0] wr_strb;
  logic [BYTE_W-1:0]   sec, min, hour, date, month, dow, year;
  logic [ALL_W-1:0]    all_regs;
  logic                adv, day_step;
  logic [BYTE_W-1:0]   rd_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wdec
    assign wr_strb[i] = wr_en_i && (wr_addr_i == SEL_W'(i));
  end

  // A write in this cycle discards the tick; a set halt bit blocks it.
  assign adv = tick_i && !sec[7] && !wr_en_i;

  bcd_rtc_time u_time (
    .clk(clk), .rst(rst), .adv_i(adv),
    .wr_sec_i(wr_strb[REG_SEC]), .wr_min_i(wr_strb[REG_MIN]), .wr_hour_i(wr_strb[REG_HOUR]),
    .wr_data_i(wr_data_i),
    .sec_o(sec), .min_o(min), .hour_o(hour), .day_step_o(day_step)
  );

  bcd_rtc_date u_date (
    .clk(clk), .rst(rst), .day_step_i(day_step),
    .wr_date_i(wr_strb[REG_DATE]), .wr_month_i(wr_strb[REG_MONTH]),
    .wr_dow_i(wr_strb[REG_DOW]), .wr_year_i(wr_strb[REG_YEAR]),
    .wr_data_i(wr_data_i),
    .date_o(date), .month_o(month), .dow_o(dow), .year_o(year)
  );

  assign all_regs = {year, dow, month, date, hour, min, sec};

  always_ff @(posedge clk) begin
    if (rst)                           rd_q <= 8'h00;
    else if (int'(rd_addr_i) < NUM_REGS) rd_q <= all_regs[int'(rd_addr_i)*BYTE_W +: BYTE_W];
    else                               rd_q <= 8'h00;
  end
  assign rd_data_o = rd_q;

  // R4: with the halt bit set and no write, nothing moves
  p_halt_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (sec[7] && !wr_en_i) |=> $stable(all_regs));
  // R11: a write elsewhere in a tick cycle leaves seconds untouched
  p_write_beats_tick_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i != 3'd0) |=> $stable(sec));
  // R2: an in-range write lands at the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && int'(wr_addr_i) < NUM_REGS)
      |=> (all_regs[int'($past(wr_addr_i))*BYTE_W +: BYTE_W] == $past(wr_data_i)));
endmodule

// File: tb/bcd_rtc_calendar_test.sv
module bcd_rtc_calendar_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic [2:0] rd_addr_i = 3'd0;
  logic [7:0] rd_data_o;

  int n_vec = 0;
  int n_bad = 0;
  // reference model, plain integers
  int m_s, m_m, m_h, m_pm, m_12, m_halt, m_date, m_mon, m_dow, m_year;

  always #2 clk = ~clk;

  bcd_rtc_calendar uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_byte(input int m12, input int pm, input int h);
    logic [7:0] b;
    b = bcd(h);
    if (m12 != 0) return {2'b10, pm[0], b[4:0]};
    return b;
  endfunction

  function automatic logic [7:0] exp_reg(input int a);
    case (a)
      0: return bcd(m_s) | {m_halt[0], 7'h00};
      1: return bcd(m_m);
      2: return hour_byte(m_12, m_pm, m_h);
      3: return bcd(m_date);
      4: return bcd(m_mon);
      5: return bcd(m_dow);
      6: return bcd(m_year);
      default: return 8'h00;
    endcase
  endfunction

  task automatic day_step();
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (m_date == mdays(m_mon, m_year)) begin
      m_date = 1;
      if (m_mon == 12) begin m_mon = 1; m_year = (m_year + 1) % 100; end
      else m_mon++;
    end else m_date++;
  endtask

  task automatic model_tick();
    if (m_halt != 0) return;
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_m++;
    if (m_m < 60) return;
    m_m = 0;
    if (m_12 != 0) begin
      if (m_h == 11) begin
        m_h = 12; m_pm = 1 - m_pm;
        if (m_pm == 0) day_step();
      end else if (m_h == 12) m_h = 1;
      else m_h++;
    end else begin
      m_h++;
      if (m_h == 24) begin m_h = 0; day_step(); end
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk) rd_addr_i = 3'(a);
    @(negedge clk) v = rd_data_o;
  endtask

  task automatic chk(input int a, input string req);
    logic [7:0] v;
    logic [7:0] e;
    rd(a, v);
    e = exp_reg(a);
    n_vec++;
    if (v !== e) begin
      n_bad++;
      $display("FAIL %s reg %0d got %h expected %h", req, a, v, e);
    end
  endtask

  task automatic chk_all(input string req);
    for (int a = 0; a < 7; a++) chk(a, req);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk) begin wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = d; end
    @(negedge clk) wr_en_i = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    model_tick();
  endtask

  task automatic load(input int m12, input int pm, input int h, input int mi, input int s,
                      input int dt, input int mo, input int yr, input int dw, input int halt);
    m_12 = m12; m_pm = pm; m_h = h; m_m = mi; m_s = s; m_halt = halt;
    m_date = dt; m_mon = mo; m_year = yr; m_dow = dw;
    for (int a = 0; a < 7; a++) wr(a, exp_reg(a));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    m_s = 0; m_m = 0; m_h = 0; m_pm = 0; m_12 = 0; m_halt = 0;
    m_date = 1; m_mon = 1; m_dow = 1; m_year = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_all("R1 reset");

    // R2: address 7 is empty, writes to it do nothing
    load(0, 0, 5, 6, 7, 8, 9, 10, 4, 0);
    chk_all("R2 write/read");
    wr(7, 8'hFF);
    chk_all("R2 write to address 7");
    rd(7, v);
    n_vec++;
    if (v !== 8'h00) begin n_bad++; $display("FAIL R2 addr 7 got %h expected 00", v); end

    // R3: seconds/minutes sweep across several minute carries
    load(0, 0, 0, 58, 0, 1, 1, 0, 1, 0);
    for (int i = 0; i < 130; i++) begin
      tick1();
      chk(0, "R3 seconds"); chk(1, "R3 minutes"); chk(2, "R3 hours");
    end

    // R5: every hour of 24-hour mode at the top of the hour
    for (int h = 0; h < 24; h++) begin
      load(0, 0, h, 59, 59, 15, 6, 24, 3, 0);
      tick1();
      chk_all("R5 24-hour step");
    end

    // R6: every hour of 12-hour mode, both halves of the day
    for (int pm = 0; pm < 2; pm++)
      for (int h = 1; h <= 12; h++) begin
        load(1, pm, h, 59, 59, 30, 4, 21, 6, 0);
        tick1();
        chk_all("R6 12-hour step");
      end

    // R7 / R9: last day of each month rolls to the next
    for (int mo = 1; mo <= 12; mo++) begin
      load(0, 0, 23, 59, 59, mdays(mo, 23), mo, 23, 2, 0);
      tick1();
      chk_all(mo == 12 ? "R9 year step" : "R7 month length");
    end

    // R8: February over every two-digit year
    for (int yr = 0; yr < 100; yr++) begin
      load(0, 0, 23, 59, 59, 28, 2, yr, 5, 0);
      tick1();
      chk_all("R8 february 28");
      if (yr % 4 == 0) begin
        load(1, 1, 11, 59, 59, 29, 2, yr, 7, 0);
        tick1();
        chk_all("R8 february 29");
      end
    end

    // R9: century wrap
    load(1, 1, 11, 59, 59, 31, 12, 99, 7, 0);
    tick1();
    chk_all("R9 year 99 wrap");

    // R10: day-of-week from each value
    for (int d = 1; d <= 7; d++) begin
      load(0, 0, 23, 59, 59, 10, 10, 10, d, 0);
      tick1();
      chk_all("R10 day-of-week");
    end

    // R4: halt freezes, clearing resumes
    load(0, 0, 23, 59, 59, 31, 12, 99, 7, 1);
    for (int i = 0; i < 5; i++) tick1();
    chk_all("R4 halted");
    wr(0, 8'h59); m_halt = 0; m_s = 59;
    tick1();
    chk_all("R4 resumed");

    // R11: write and tick in one cycle; write wins, no carry
    load(0, 0, 0, 59, 58, 1, 1, 1, 1, 0);
    @(negedge clk) begin tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 8'h59; end
    @(negedge clk) begin tick_i = 1'b0; wr_en_i = 1'b0; end
    m_s = 59;
    chk_all("R11 write on seconds beats tick");
    @(negedge clk) begin tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd5; wr_data_i = 8'h04; end
    @(negedge clk) begin tick_i = 1'b0; wr_en_i = 1'b0; end
    m_dow = 4;
    chk_all("R11 write elsewhere beats tick");
    tick1();
    chk_all("R11 tick after collision");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule